// File: doc/BRIEF.md
# Multiprocessor Thread-Block Admission Controller

This controller sits beside one streaming multiprocessor and decides whether a thread block offered by an upstream dispatcher may become resident there. Each offer carries three demands: a thread count, a register count per thread and a shared-memory byte count. The controller weighs all four per-multiprocessor budgets in the same cycle: threads, registers, shared memory and resident blocks. A block is taken only when every budget still holds after it is added.

On acceptance the block's demands are reserved all at once in one of a fixed set of slot records, and the slot number goes back to the dispatcher. When a block finishes, a retire request naming its slot gives back exactly what that slot took. Running totals of the four resources are visible at all times. An offer that cannot fit yet is held off by keeping ready low until enough resources are retired. An offer with too many threads is consumed and flagged as malformed.

Top module: `sm_admit_ctrl`

## Requirements
- R1: After reset the block, thread, register and shared-memory totals are all zero, no slot is occupied and the retire error flag is low.
- R2: An offer is refused if the resident thread total plus its thread count would exceed 768. Reaching exactly 768 is allowed.
- R3: No more than 8 blocks are ever resident. A ninth offer is refused until a slot is retired.
- R4: An accepted block takes threads × registers-per-thread from a pool of 8192 registers. The offer is refused if that product exceeds the remaining pool. Using exactly the whole pool is allowed.
- R5: Shared memory is reserved against a parameter capacity (default 16384 bytes). The offer is refused if its byte count exceeds what is left.
- R6: An offer asking for more than 512 threads is malformed. It is consumed (ready high) with the malformed flag high in that cycle, and it is never granted.
- R7: An offer that is well formed but does not fit sees ready low and no grant. It leaves all totals untouched for as long as it waits.
- R8: A grant pulses for one cycle together with ready and returns the lowest-numbered free slot (0 to 7). A retire naming that slot returns exactly that block's threads, registers and shared memory.
- R9: When a retire and an offer arrive in the same cycle, the retire is applied first. The offer may then use the freed resources and the freed slot.
- R10: A retire naming an unoccupied slot changes nothing and sets a retire error flag that stays high until reset.
- R11: The four totals always equal the sums of the blocks currently resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| offer_valid | input | 1 | Dispatcher presents a block |
| offer_ready | output | 1 | Offer is consumed this cycle (granted or malformed) |
| offer_threads | input | 10 | Threads in the offered block |
| offer_rpt | input | 8 | Registers per thread |
| offer_smem | input | 16 | Shared-memory bytes requested |
| grant | output | 1 | Block accepted this cycle |
| grant_slot | output | 3 | Slot given to the accepted block |
| offer_bad | output | 1 | Offered block is malformed (too many threads) |
| retire_valid | input | 1 | A resident block has finished |
| retire_slot | input | 3 | Slot of the finished block |
| retire_err | output | 1 | Sticky: a retire named an empty slot |
| blk_cnt | output | 4 | Resident blocks |
| thr_cnt | output | 10 | Resident threads |
| reg_cnt | output | 14 | Registers in use |
| smem_cnt | output | 15 | Shared-memory bytes in use |

## Verification
A slot record that holds the wrong amounts does not show at once. It shows when that slot is retired: the totals then drop by the wrong amount on the next clock edge, and later offers are granted or refused at the wrong boundary. A total that drifts shows directly on the count outputs one cycle after the grant or retire that caused it. A wrong busy bit shows as a repeated or skipped slot number on the next grant, or as a wrongly flagged retire. For this reason the bench follows each grant with a retire of the same slot and compares the totals after every step.

// File: rtl/sm_admit_pkg.sv
package sm_admit_pkg;

  // Verdict on the offer currently presented.
  typedef enum logic [1:0] {
    VERDICT_IDLE,
    VERDICT_TAKE,
    VERDICT_WAIT,
    VERDICT_BAD
  } verdict_e;

  // Registers a block needs: one per thread per register slot.
  function automatic int unsigned reg_demand(int unsigned threads, int unsigned per_thread);
    return threads * per_thread;
  endfunction

  // True when adding 'want' to 'used' stays within 'cap'.
  function automatic logic within_cap(int unsigned used, int unsigned want, int unsigned cap);
    return (used + want) <= cap;
  endfunction

endpackage

// File: rtl/sm_admit_fit.sv
module sm_admit_fit #(
  parameter int MAX_THR     = 768,
  parameter int MAX_BLK     = 8,
  parameter int REG_POOL    = 8192,
  parameter int SMEM_BYTES  = 16384,
  parameter int BLK_THR_MAX = 512,
  parameter int REQ_THR_W   = 10,
  parameter int NEED_W      = 18,
  parameter int REQ_SMEM_W  = 16,
  parameter int BLK_CW      = 4,
  parameter int THR_CW      = 10,
  parameter int REG_CW      = 14,
  parameter int SMEM_CW     = 15
) (
  input  logic [BLK_CW-1:0]     blk_eff,
  input  logic [THR_CW-1:0]     thr_eff,
  input  logic [REG_CW-1:0]     reg_eff,
  input  logic [SMEM_CW-1:0]    smem_eff,
  input  logic [REQ_THR_W-1:0]  req_thr,
  input  logic [NEED_W-1:0]     req_regs,
  input  logic [REQ_SMEM_W-1:0] req_smem,
  output logic                  malformed,
  output logic                  fit_all
);
  import sm_admit_pkg::*;

  logic thr_ok, blk_ok, reg_ok, smem_ok;

  always_comb begin
    malformed = 32'(req_thr) > 32'(BLK_THR_MAX);
    thr_ok    = within_cap(32'(thr_eff),  32'(req_thr),  32'(MAX_THR));
    blk_ok    = within_cap(32'(blk_eff),  32'd1,         32'(MAX_BLK));
    reg_ok    = within_cap(32'(reg_eff),  32'(req_regs), 32'(REG_POOL));
    smem_ok   = within_cap(32'(smem_eff), 32'(req_smem), 32'(SMEM_BYTES));
    fit_all   = !malformed && thr_ok && blk_ok && reg_ok && smem_ok;
  end

endmodule

// File: rtl/sm_admit_slots.sv
module sm_admit_slots #(
  parameter int MAX_BLK   = 8,
  parameter int SLOT_W    = 3,
  parameter int REQ_THR_W = 10,
  parameter int REG_CW    = 14,
  parameter int SMEM_CW   = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [REQ_THR_W-1:0] alloc_thr,
  input  logic [REG_CW-1:0]    alloc_regs,
  input  logic [SMEM_CW-1:0]   alloc_smem,
  input  logic                 rel_en,
  input  logic [SLOT_W-1:0]    rel_slot,
  output logic                 rel_hit,
  output logic [REQ_THR_W-1:0] rel_thr,
  output logic [REG_CW-1:0]    rel_regs,
  output logic [SMEM_CW-1:0]   rel_smem,
  output logic                 free_any,
  output logic [SLOT_W-1:0]    free_slot
);

  logic [MAX_BLK-1:0]   busy;
  logic [MAX_BLK-1:0]   busy_eff;
  logic [REQ_THR_W-1:0] thr_q  [MAX_BLK];
  logic [REG_CW-1:0]    regs_q [MAX_BLK];
  logic [SMEM_CW-1:0]   smem_q [MAX_BLK];
  logic                 slot_in_range;

  assign slot_in_range = 32'(rel_slot) < 32'(MAX_BLK);
  assign rel_hit  = rel_en && slot_in_range && busy[rel_slot];
  assign rel_thr  = thr_q[rel_slot];
  assign rel_regs = regs_q[rel_slot];
  assign rel_smem = smem_q[rel_slot];

  // Occupancy as seen after this cycle's retire (retire goes first).
  for (genvar g = 0; g < MAX_BLK; g++) begin : g_eff
    assign busy_eff[g] = busy[g] && !(rel_hit && (rel_slot == SLOT_W'(g)));
  end

  // Lowest free slot wins.
  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = MAX_BLK - 1; i >= 0; i--) begin
      if (!busy_eff[i]) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      for (int i = 0; i < MAX_BLK; i++) begin
        thr_q[i]  <= '0;
        regs_q[i] <= '0;
        smem_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < MAX_BLK; i++) begin
        if (alloc_en && free_slot == SLOT_W'(i)) begin
          busy[i]   <= 1'b1;
          thr_q[i]  <= alloc_thr;
          regs_q[i] <= alloc_regs;
          smem_q[i] <= alloc_smem;
        end else if (rel_hit && rel_slot == SLOT_W'(i)) begin
          busy[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sm_admit_ctrl.sv
module sm_admit_ctrl #(
  parameter int MAX_THR     = 768,
  parameter int MAX_BLK     = 8,
  parameter int REG_POOL    = 8192,
  parameter int SMEM_BYTES  = 16384,
  parameter int BLK_THR_MAX = 512,
  parameter int REQ_THR_W   = 10,
  parameter int RPT_W       = 8,
  parameter int REQ_SMEM_W  = 16,
  localparam int SLOT_W     = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1,
  localparam int BLK_CW     = $clog2(MAX_BLK + 1),
  localparam int THR_CW     = $clog2(MAX_THR + 1),
  localparam int REG_CW     = $clog2(REG_POOL + 1),
  localparam int SMEM_CW    = $clog2(SMEM_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  offer_valid,
  output logic                  offer_ready,
  input  logic [REQ_THR_W-1:0]  offer_threads,
  input  logic [RPT_W-1:0]      offer_rpt,
  input  logic [REQ_SMEM_W-1:0] offer_smem,
  output logic                  grant,
  output logic [SLOT_W-1:0]     grant_slot,
  output logic                  offer_bad,
  input  logic                  retire_valid,
  input  logic [SLOT_W-1:0]     retire_slot,
  output logic                  retire_err,
  output logic [BLK_CW-1:0]     blk_cnt,
  output logic [THR_CW-1:0]     thr_cnt,
  output logic [REG_CW-1:0]     reg_cnt,
  output logic [SMEM_CW-1:0]    smem_cnt
);
  import sm_admit_pkg::*;

  localparam int NEED_W = REQ_THR_W + RPT_W;

  // Named internal events for the checker.
  logic                 rel_fire;
  logic                 rel_stray;
  logic                 malformed;
  logic                 fit_all;
  logic                 free_any;
  verdict_e             verdict;

  logic [NEED_W-1:0]    reg_need;
  logic [REQ_THR_W-1:0] rel_thr;
  logic [REG_CW-1:0]    rel_regs;
  logic [SMEM_CW-1:0]   rel_smem;

  logic [BLK_CW-1:0]    blk_eff;
  logic [THR_CW-1:0]    thr_eff;
  logic [REG_CW-1:0]    reg_eff;
  logic [SMEM_CW-1:0]   smem_eff;

  assign reg_need = NEED_W'(reg_demand(32'(offer_threads), 32'(offer_rpt)));

  sm_admit_slots #(
    .MAX_BLK(MAX_BLK), .SLOT_W(SLOT_W), .REQ_THR_W(REQ_THR_W),
    .REG_CW(REG_CW), .SMEM_CW(SMEM_CW)
  ) slots_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(grant),
    .alloc_thr(offer_threads),
    .alloc_regs(REG_CW'(reg_need)),
    .alloc_smem(SMEM_CW'(offer_smem)),
    .rel_en(retire_valid), .rel_slot(retire_slot),
    .rel_hit(rel_fire), .rel_thr(rel_thr), .rel_regs(rel_regs), .rel_smem(rel_smem),
    .free_any(free_any), .free_slot(grant_slot)
  );

  assign rel_stray = retire_valid && !rel_fire;

  // Totals with this cycle's retire already taken out.
  always_comb begin
    blk_eff  = blk_cnt  - (rel_fire ? BLK_CW'(1)        : '0);
    thr_eff  = thr_cnt  - (rel_fire ? THR_CW'(rel_thr)  : '0);
    reg_eff  = reg_cnt  - (rel_fire ? rel_regs          : '0);
    smem_eff = smem_cnt - (rel_fire ? rel_smem          : '0);
  end

  sm_admit_fit #(
    .MAX_THR(MAX_THR), .MAX_BLK(MAX_BLK), .REG_POOL(REG_POOL),
    .SMEM_BYTES(SMEM_BYTES), .BLK_THR_MAX(BLK_THR_MAX),
    .REQ_THR_W(REQ_THR_W), .NEED_W(NEED_W), .REQ_SMEM_W(REQ_SMEM_W),
    .BLK_CW(BLK_CW), .THR_CW(THR_CW), .REG_CW(REG_CW), .SMEM_CW(SMEM_CW)
  ) fit_i (
    .blk_eff(blk_eff), .thr_eff(thr_eff), .reg_eff(reg_eff), .smem_eff(smem_eff),
    .req_thr(offer_threads), .req_regs(reg_need), .req_smem(offer_smem),
    .malformed(malformed), .fit_all(fit_all)
  );

  always_comb begin
    if (!offer_valid)             verdict = VERDICT_IDLE;
    else if (malformed)           verdict = VERDICT_BAD;
    else if (fit_all && free_any) verdict = VERDICT_TAKE;
    else                          verdict = VERDICT_WAIT;
  end

  assign grant       = (verdict == VERDICT_TAKE);
  assign offer_bad   = (verdict == VERDICT_BAD);
  assign offer_ready = grant || offer_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt    <= '0;
      thr_cnt    <= '0;
      reg_cnt    <= '0;
      smem_cnt   <= '0;
      retire_err <= 1'b0;
    end else begin
      blk_cnt    <= blk_eff  + (grant ? BLK_CW'(1)               : '0);
      thr_cnt    <= thr_eff  + (grant ? THR_CW'(offer_threads)   : '0);
      reg_cnt    <= reg_eff  + (grant ? REG_CW'(reg_need)        : '0);
      smem_cnt   <= smem_eff + (grant ? SMEM_CW'(offer_smem)     : '0);
      retire_err <= retire_err || rel_stray;
    end
  end

endmodule

// File: rtl/sm_admit_chk.sv
module sm_admit_chk #(
  parameter int MAX_THR    = 768,
  parameter int MAX_BLK    = 8,
  parameter int REG_POOL   = 8192,
  parameter int SMEM_BYTES = 16384,
  parameter int BLK_CW     = 4,
  parameter int THR_CW     = 10,
  parameter int REG_CW     = 14,
  parameter int SMEM_CW    = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               offer_valid,
  input logic               offer_ready,
  input logic               grant,
  input logic               offer_bad,
  input logic               retire_err,
  input logic               rel_fire,
  input logic               rel_stray,
  input logic [BLK_CW-1:0]  blk_cnt,
  input logic [THR_CW-1:0]  thr_cnt,
  input logic [REG_CW-1:0]  reg_cnt,
  input logic [SMEM_CW-1:0] smem_cnt
);

  assert_thr_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(thr_cnt) <= 32'(MAX_THR));

  assert_blk_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(blk_cnt) <= 32'(MAX_BLK));

  assert_reg_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(reg_cnt) <= 32'(REG_POOL));

  assert_smem_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(smem_cnt) <= 32'(SMEM_BYTES));

  assert_bad_never_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    offer_bad |-> !grant);

  assert_wait_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !offer_ready) |-> !grant);

  assert_wait_totals_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !offer_ready && !rel_fire) |=>
      ($stable(thr_cnt) && $stable(blk_cnt) && $stable(reg_cnt) && $stable(smem_cnt)));

  assert_grant_adds_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !rel_fire) |=> (blk_cnt == $past(blk_cnt) + BLK_CW'(1)));

  assert_stray_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_stray |=> retire_err);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retire_err |=> retire_err);

endmodule

bind sm_admit_ctrl sm_admit_chk #(
  .MAX_THR(MAX_THR), .MAX_BLK(MAX_BLK), .REG_POOL(REG_POOL), .SMEM_BYTES(SMEM_BYTES),
  .BLK_CW(BLK_CW), .THR_CW(THR_CW), .REG_CW(REG_CW), .SMEM_CW(SMEM_CW)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .offer_valid(offer_valid), .offer_ready(offer_ready),
  .grant(grant), .offer_bad(offer_bad), .retire_err(retire_err),
  .rel_fire(rel_fire), .rel_stray(rel_stray),
  .blk_cnt(blk_cnt), .thr_cnt(thr_cnt), .reg_cnt(reg_cnt), .smem_cnt(smem_cnt)
);

// File: tb/sm_admit_ctrl_tb_top.sv
module sm_admit_ctrl_tb_top;

  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic        offer_ready;
  logic [9:0]  offer_threads = '0;
  logic [7:0]  offer_rpt = '0;
  logic [15:0] offer_smem = '0;
  logic        grant;
  logic [2:0]  grant_slot;
  logic        offer_bad;
  logic        retire_valid = 1'b0;
  logic [2:0]  retire_slot = '0;
  logic        retire_err;
  logic [3:0]  blk_cnt;
  logic [9:0]  thr_cnt;
  logic [13:0] reg_cnt;
  logic [14:0] smem_cnt;

  always #5 clk = ~clk;

  sm_admit_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_threads(offer_threads), .offer_rpt(offer_rpt), .offer_smem(offer_smem),
    .grant(grant), .grant_slot(grant_slot), .offer_bad(offer_bad),
    .retire_valid(retire_valid), .retire_slot(retire_slot), .retire_err(retire_err),
    .blk_cnt(blk_cnt), .thr_cnt(thr_cnt), .reg_cnt(reg_cnt), .smem_cnt(smem_cnt)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int exp_q[$];

  // Bench-side model of the slot table.
  bit m_busy[NB];
  int m_thr[NB], m_reg[NB], m_smem[NB];
  bit m_err = 0;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_totals(string req);
    int b = 0, t = 0, r = 0, s = 0;
    for (int i = 0; i < NB; i++) if (m_busy[i]) begin
      b++; t += m_thr[i]; r += m_reg[i]; s += m_smem[i];
    end
    @(negedge clk); #4;
    chk({req, " blocks"}, int'(blk_cnt), b);
    chk({req, " threads"}, int'(thr_cnt), t);
    chk({req, " registers"}, int'(reg_cnt), r);
    chk({req, " smem"}, int'(smem_cnt), s);
    chk({req, " retire_err"}, int'(retire_err), int'(m_err));
  endtask

  // Offer a block, optionally with a retire in the same cycle; a refused
  // offer is held for 'cyc' cycles.
  task automatic offer(int thr, int rpt, int smem, bit rv, int rs, int cyc, string req);
    int b = 0, t = 0, r = 0, s = 0, slot = -1;
    bit hit, bad, fits;
    hit = rv && m_busy[rs];
    for (int i = 0; i < NB; i++) if (m_busy[i] && !(hit && i == rs)) begin
      b++; t += m_thr[i]; r += m_reg[i]; s += m_smem[i];
    end
    for (int i = NB - 1; i >= 0; i--) if (!(m_busy[i] && !(hit && i == rs))) slot = i;
    bad  = thr > 512;
    fits = !bad && (t + thr <= 768) && (b + 1 <= 8) && (r + thr * rpt <= 8192)
           && (s + smem <= 16384);
    @(negedge clk); #1;
    offer_valid = 1'b1; offer_threads = 10'(thr); offer_rpt = 8'(rpt);
    offer_smem = 16'(smem); retire_valid = rv; retire_slot = 3'(rs);
    if (fits) exp_q.push_back(slot);
    for (int k = 0; k < ((fits || bad) ? 1 : cyc); k++) begin
      if (k > 0) begin @(negedge clk); #4; end else #3;
      chk({req, " ready"}, int'(offer_ready), int'(fits || bad));
      chk({req, " grant"}, int'(grant), int'(fits));
      chk({req, " malformed"}, int'(offer_bad), int'(bad));
      @(posedge clk); #1;
      retire_valid = 1'b0;
    end
    offer_valid = 1'b0;
    if (hit) m_busy[rs] = 0;
    if (rv && !hit) m_err = 1;
    if (fits) begin
      m_busy[slot] = 1; m_thr[slot] = thr; m_reg[slot] = thr * rpt; m_smem[slot] = smem;
    end
  endtask

  task automatic retire(int rs);
    @(negedge clk); #1;
    retire_valid = 1'b1; retire_slot = 3'(rs);
    @(posedge clk); #1;
    retire_valid = 1'b0;
    if (m_busy[rs]) m_busy[rs] = 0; else m_err = 1;
  endtask

  // Scoreboard monitor: every grant must match the next expected slot (R8).
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && grant) begin
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R8 unexpected grant: actual slot %0d expected none", grant_slot);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk("R8 grant slot", int'(grant_slot), e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_totals("R1 reset");

    offer(256, 8, 1024, 0, 0, 1, "R4 first block");
    check_totals("R11 after first");
    offer(513, 1, 0, 0, 0, 1, "R6 oversized");
    check_totals("R6 unchanged");
    offer(256, 8, 0, 0, 0, 1, "R8 second block");
    offer(512, 1, 0, 0, 0, 3, "R2 R7 thread overflow held");
    check_totals("R7 held totals");
    offer(512, 1, 0, 1, 0, 1, "R9 retire-first reaches 768");
    check_totals("R2 R9 totals");
    retire(0); retire(1);
    check_totals("R8 exact return");

    offer(256, 32, 0, 0, 0, 1, "R4 full pool");
    offer(1, 1, 0, 0, 0, 2, "R4 pool exhausted");
    offer(1, 0, 0, 0, 0, 1, "R4 zero-register block");
    check_totals("R4 totals");
    retire(0); retire(1);

    offer(1, 0, 16384, 0, 0, 1, "R5 full smem");
    offer(1, 0, 1, 0, 0, 2, "R5 smem exhausted");
    check_totals("R5 totals");
    retire(0);

    for (int i = 0; i < 8; i++) offer(1, 0, 0, 0, 0, 1, "R3 fill slots");
    offer(1, 0, 0, 0, 0, 2, "R3 ninth refused");
    check_totals("R3 eight resident");
    retire(3);
    offer(1, 0, 0, 0, 0, 1, "R8 reuse freed slot");
    retire(3);
    check_totals("R10 before stray");
    retire(3);
    check_totals("R10 stray retire");
    offer(1, 0, 0, 0, 0, 1, "R10 after stray");
    check_totals("R10 flag sticky");

    repeat (2) @(negedge clk);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule